// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block supplies the column address for every data beat of a memory burst. A single-cycle start pulse captures a 9-bit starting column, a 3-bit burst-length code and an ordering bit. From the next clock on, the block presents one column per cycle on `col_o`. It marks each beat with `valid_o` and flags the final beat of a fixed-length burst with `last_o`.

For fixed lengths of 2, 4 or 8, the beat address moves only inside the aligned block of that size, so no carry reaches the upper column bits. The ordering is either sequential (the low field counts up) or interleaved (the beat count is XORed into the low field). A full-page burst counts up through the whole 9-bit column space and wraps from 511 to 0. It keeps running until a stop request arrives.

A stop request ends any running burst. `discard_o` then rises and stays high until the next start, so a write path can drop whatever beats were still pending. A start that arrives during a burst abandons the current sequence and begins again from the new configuration.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `discard_o` are all low.
- R2: A start pulse sampled on a clock edge makes `valid_o` high in the following cycle, with `col_o` equal to the captured start column (beat 0). Start column, length code and ordering bit are captured only on that edge.
- R3: In sequential order with fixed length BL and mask m = BL-1, beat k has address `(start & ~m) | ((start + k) & m)`. The bits above the mask stay equal to those of the start column.
- R4: In interleaved order (`ilv_i` = 1) with fixed length BL, beat k has address `(start & ~m) | ((start ^ k) & m)`.
- R5: Length code: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page. Codes 3'b100, 3'b101 and 3'b110 give 1 beat. A fixed burst keeps `valid_o` high for exactly BL cycles.
- R6: `last_o` is high only on beat BL-1 of a fixed burst and always implies `valid_o`. After a last beat with no new start, `valid_o` is low in the next cycle.
- R7: In full-page mode, beat k has address `(start + k) mod 512`. The ordering bit has no effect, `last_o` never rises, and the burst runs until stopped.
- R8: A stop request sampled while a burst runs (and with no start) makes `valid_o` low and `discard_o` high in the next cycle. `discard_o` stays high until the next start. A stop while idle changes nothing.
- R9: A start during a running burst restarts from the new start column with the new length and ordering, and clears `discard_o`.
- R10: When start and stop are sampled on the same edge, the start takes effect and the stop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; captures the burst configuration |
| start_col_i | input | 9 | Starting column address |
| bl_code_i | input | 3 | Burst-length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| stop_i | input | 1 | Burst-stop request |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final beat of a fixed burst |
| discard_o | output | 1 | A stop has ended the burst; drop pending write beats |

## Verification
All results are due one clock after the stimulus that causes them. Beat 0 appears in the cycle after the start edge, and each later beat follows one cycle after the one before. `valid_o` falls in the cycle after a last beat or a stop edge, and `discard_o` rises in that same cycle. The bench drives inputs on falling edges and compares on the following falling edge, so each check lands exactly one register stage after its cause. It steps beat by beat, computing the expected column from the start value modulo the burst size. The sweep covers every length code, both orderings and several start columns, including aligned, unaligned and top-of-range values.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  // Decoded burst length: lg is log2 of a fixed length, full marks page mode.
  typedef struct packed {
    logic       full;
    logic [1:0] lg;
  } blen_t;

  function automatic blen_t decode_bl(input logic [2:0] code);
    blen_t r;
    r.full = 1'b0;
    r.lg   = 2'd0;
    case (code)
      3'b001:  r.lg = 2'd1;
      3'b010:  r.lg = 2'd2;
      3'b011:  r.lg = 2'd3;
      3'b111:  r.full = 1'b1;
      default: r.lg = 2'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/colgen_cfg_reg.sv
module colgen_cfg_reg
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] start_q,
  output blen_t            blen_q,
  output logic             ilv_q
);

  blen_t blen_d;
  assign blen_d = decode_bl(bl_code_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      blen_q  <= '0;
      ilv_q   <= 1'b0;
    end else if (load_i) begin
      start_q <= start_col_i;
      blen_q  <= blen_d;
      ilv_q   <= ilv_i & ~blen_d.full;
    end
  end

endmodule

// File: rtl/colgen_beat_ctrl.sv
module colgen_beat_ctrl #(
  parameter int BEAT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              stop_i,
  input  logic              full_i,
  input  logic [1:0]        lg_i,
  output logic [BEAT_W-1:0] beat_q,
  output logic              active_q,
  output logic              discard_q,
  output logic              last_o,
  output logic              stop_evt_o,
  output logic              end_evt_o
);

  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  logic [BEAT_W-1:0] last_idx;
  logic              at_last;

  assign last_idx   = (ONE << lg_i) - ONE;
  assign at_last    = !full_i && (beat_q == last_idx);
  assign stop_evt_o = active_q && stop_i && !load_i;
  assign end_evt_o  = active_q && at_last && !stop_i && !load_i;
  assign last_o     = active_q && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q    <= '0;
      active_q  <= 1'b0;
      discard_q <= 1'b0;
    end else if (load_i) begin
      beat_q    <= '0;
      active_q  <= 1'b1;
      discard_q <= 1'b0;
    end else if (stop_evt_o) begin
      active_q  <= 1'b0;
      discard_q <= 1'b1;
    end else if (end_evt_o) begin
      active_q  <= 1'b0;
    end else if (active_q) begin
      beat_q    <= beat_q + ONE;
    end
  end

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] start_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [1:0]       lg_i,
  input  logic             full_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);

  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  function automatic logic [COL_W-1:0] map_col(
    input logic [COL_W-1:0] s,
    input logic [COL_W-1:0] k,
    input logic [1:0]       lg,
    input logic             full,
    input logic             ilv
  );
    logic [COL_W-1:0] m;
    logic [COL_W-1:0] off;
    if (full) return s + k;
    m   = (ONE << lg) - ONE;
    off = ilv ? (s ^ k) : (s + k);
    return (s & ~m) | (off & m);
  endfunction

  assign col_o = map_col(start_i, beat_i, lg_i, full_i, ilv_i);

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             discard_o
);

  localparam int BEAT_W = COL_W;

  logic [COL_W-1:0]  start_q;
  blen_t             blen_q;
  logic              ilv_q;
  logic [BEAT_W-1:0] beat_q;
  logic              active_q;
  logic              discard_q;
  logic              last_w;
  logic              stop_evt;
  logic              end_evt;
  logic              cfg_full;

  assign cfg_full = blen_q.full;

  colgen_cfg_reg #(.COL_W(COL_W)) cfg_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (start_i),
    .start_col_i (start_col_i),
    .bl_code_i   (bl_code_i),
    .ilv_i       (ilv_i),
    .start_q     (start_q),
    .blen_q      (blen_q),
    .ilv_q       (ilv_q)
  );

  colgen_beat_ctrl #(.BEAT_W(BEAT_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_i),
    .stop_i     (stop_i),
    .full_i     (blen_q.full),
    .lg_i       (blen_q.lg),
    .beat_q     (beat_q),
    .active_q   (active_q),
    .discard_q  (discard_q),
    .last_o     (last_w),
    .stop_evt_o (stop_evt),
    .end_evt_o  (end_evt)
  );

  colgen_addr_map #(.COL_W(COL_W)) map_i (
    .start_i (start_q),
    .beat_i  (beat_q),
    .lg_i    (blen_q.lg),
    .full_i  (blen_q.full),
    .ilv_i   (ilv_q),
    .col_o   (col_o)
  );

  assign valid_o   = active_q;
  assign last_o    = last_w;
  assign discard_o = discard_q;

endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             discard_o,
  input logic             cfg_full,
  input logic             stop_evt,
  input logic             end_evt
);

  p_start_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);

  p_start_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (col_o == $past(start_col_i)));

  p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!valid_o && discard_o));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !start_i) |=> $stable(discard_o));

  p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> !valid_o);

  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  p_no_last_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cfg_full) |-> !last_o);

  p_full_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cfg_full && $past(valid_o) && !$past(start_i))
      |-> (col_o == COL_W'($past(col_o) + 1'b1)));

  p_upper_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !cfg_full && $past(valid_o) && !$past(start_i))
      |-> (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));

  p_start_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && stop_i) |=> (valid_o && !discard_o));

endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .discard_o   (discard_o),
  .cfg_full    (cfg_full),
  .stop_evt    (stop_evt),
  .end_evt     (end_evt)
);

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb_top;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] bl_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o;
  logic       last_o;
  logic       discard_o;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  sdram_burst_colgen dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .bl_code_i(bl_code_i), .ilv_i(ilv_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .discard_o(discard_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int beats_of(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 1;
    endcase
  endfunction

  // Expected column: split the start into block base and offset, then step.
  function automatic int exp_col(input int s, input int k, input int n, input bit ilv);
    int lo = s % n;
    int off = ilv ? (lo ^ k) : ((lo + k) % n);
    return s - lo + off;
  endfunction

  task automatic pulse_start(input int s, input int code, input bit ilv, input bit stp);
    start_i = 1'b1; start_col_i = 9'(s); bl_code_i = 3'(code); ilv_i = ilv; stop_i = stp;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
  endtask

  task automatic run_fixed(input int s, input int code, input bit ilv);
    int n = beats_of(code);
    @(negedge clk);
    pulse_start(s, code, ilv, 1'b0);
    for (int k = 0; k < n; k++) begin
      int e = exp_col(s, k, n, ilv);
      chk(valid_o == 1'b1, "R5 valid during burst", int'(valid_o), 1);
      if (ilv) chk(col_o == 9'(e), "R4 interleaved column", int'(col_o), e);
      else     chk(col_o == 9'(e), "R3 sequential column", int'(col_o), e);
      chk(last_o == (k == n-1), "R6 last flag", int'(last_o), int'(k == n-1));
      chk(discard_o == 1'b0, "R9 discard clear after start", int'(discard_o), 0);
      @(negedge clk);
    end
    chk(valid_o == 1'b0, "R5 burst length ends", int'(valid_o), 0);
    chk(last_o == 1'b0, "R6 last low when idle", int'(last_o), 0);
  endtask

  task automatic run_full(input int s, input bit ilv, input int nb);
    @(negedge clk);
    pulse_start(s, 7, ilv, 1'b0);
    for (int k = 0; k < nb; k++) begin
      chk(col_o == 9'((s + k) % 512), "R7 full page column", int'(col_o), (s + k) % 512);
      chk(valid_o && !last_o, "R7 valid and no last", int'({valid_o, last_o}), 2);
      if (k == nb-1) stop_i = 1'b1;
      @(negedge clk);
    end
    stop_i = 1'b0;
    chk(valid_o == 1'b0, "R8 stop drops valid", int'(valid_o), 0);
    chk(discard_o == 1'b1, "R8 discard after stop", int'(discard_o), 1);
    @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    @(negedge clk);
    chk(discard_o == 1'b1 && valid_o == 1'b0, "R8 idle stop no effect",
        int'({discard_o, valid_o}), 2);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int starts[5] = '{0, 5, 171, 510, 511};
    repeat (3) @(negedge clk);
    chk({valid_o, last_o, discard_o} == 3'b000, "R1 reset outputs",
        int'({valid_o, last_o, discard_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({valid_o, last_o, discard_o} == 3'b000, "R1 idle after reset",
        int'({valid_o, last_o, discard_o}), 0);

    // R2 R3 R4 R5 R6: every fixed length code, both orders, several starts
    for (int c = 0; c < 7; c++)
      for (int o = 0; o < 2; o++)
        foreach (starts[i]) run_fixed(starts[i], c, o[0]);

    // R7 full page with wrap, interleave bit ignored; R8 stop and idle stop
    run_full(505, 1'b0, 12);
    run_full(508, 1'b1, 9);

    // R9 fresh start clears discard
    run_fixed(37, 2, 1'b0);

    // R8 stop inside a fixed burst of 8
    @(negedge clk);
    pulse_start(7, 3, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      chk(col_o == 9'(exp_col(7, k, 8, 1'b0)), "R8 beats before stop",
          int'(col_o), exp_col(7, k, 8, 1'b0));
      if (k == 3) stop_i = 1'b1;
      @(negedge clk);
    end
    stop_i = 1'b0;
    chk(!valid_o && discard_o, "R8 fixed burst stopped", int'({valid_o, discard_o}), 1);

    // R9 restart mid-burst with new config
    @(negedge clk);
    pulse_start(16, 3, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    pulse_start(291, 2, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) begin
      chk(col_o == 9'(exp_col(291, k, 4, 1'b1)) && valid_o, "R9 restart column",
          int'(col_o), exp_col(291, k, 4, 1'b1));
      chk(last_o == (k == 3), "R9 restart last", int'(last_o), int'(k == 3));
      @(negedge clk);
    end
    chk(valid_o == 1'b0, "R9 restarted burst ends", int'(valid_o), 0);

    // R10 start and stop together during full page
    @(negedge clk);
    pulse_start(100, 7, 1'b0, 1'b0);
    @(negedge clk);
    pulse_start(85, 1, 1'b0, 1'b1);
    for (int k = 0; k < 2; k++) begin
      chk(col_o == 9'(exp_col(85, k, 2, 1'b0)) && valid_o && !discard_o,
          "R10 start wins over stop", int'(col_o), exp_col(85, k, 2, 1'b0));
      @(negedge clk);
    end
    chk(valid_o == 1'b0, "R10 burst after tie ends", int'(valid_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule